// File: doc/BRIEF.md
# Wide Register Host Access Bridge

This bridge lets a host bus that moves one 32-bit dword per beat reach a bank of 128-bit control and status registers. Each host beat is a read or a write of one dword. It is accepted in the cycle in which `host_valid` is high. The bridge turns these beats into atomic 128-bit operations on a plain wide-register port.

Reads are served through a latch. The first dword of a register, or any dword of a register that is not the one currently latched, pulls the whole 128-bit value from the register file in that same cycle. The remaining dwords of that register are then served from the latch, so a read-to-clear field is consumed only once.

Writes are gathered in a collector, which stores the 128-bit value in one strobe once all four dwords have arrived. Two descriptor-pointer offsets and two single-dword offsets follow their own rules, described below. Every offset rule repeats on each 8 KiB page.

Top module: `wreg_bridge`

## Requirements
- R1: A byte address splits into a page (address / 0x2000) and a page offset (address mod 0x2000). A wide register base is the address with its low four bits cleared. Dword `i` of a wide register sits at base+4·i and occupies bits 32·i+31:32·i of the 128-bit data. Every offset rule applies identically on every page.
- R2: A read of dword 0 of a wide register, or of any dword of a wide register other than the latched one, raises `reg_re` with `reg_addr` = base in that cycle. It returns that dword of `reg_rdata` and loads the whole 128-bit value into the latch.
- R3: A read of dword 1, 2 or 3 of the latched register leaves `reg_re` low and returns the latched dword.
- R4: A read of a single-dword register (page offset 0x400 or 0x420) raises `reg_re` with the dword address, returns `reg_rdata[31:0]` and leaves the latch unchanged.
- R5: A write to a normal wide register raises `reg_we` only in the beat that completes all four dwords, with `reg_addr` = base and all 128 bits written at once.
- R6: A normal wide write to a base other than the one being collected restarts the collector with only the new dword, and the earlier partial data is discarded.
- R7: A write to dword 3 of a descriptor pointer (page offset 0x830 or 0xA10) always commits. Low dwords not held in the collector for that register are written as zero, and the collector then becomes empty.
- R8: A write to dword 0, 1 or 2 of a descriptor pointer is dropped while the collector holds data for another register, and the collector keeps its contents.
- R9: A write to the timer-command dword (page offset 0x420) is stored directly (`reg_we`, `reg_wdata` = {96'b0, data}) and empties the collector.
- R10: A write to the event-pointer dword (page offset 0x400) is stored directly and leaves the collector untouched.
- R11: Reset clears the collector and the latch. With `host_valid` low, neither strobe is raised.
- R12: A descriptor dword-3 commit while the collector holds another register writes zeros in the low 96 bits and keeps the other register's collected data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host beat present this cycle |
| host_write | input | 1 | 1 = write beat, 0 = read beat |
| host_addr | input | ADDR_W | Byte address of the dword |
| host_wdata | input | 32 | Write dword |
| host_rdata | output | 32 | Read dword, same cycle |
| reg_addr | output | ADDR_W | Register file address |
| reg_wdata | output | 128 | Register file write data |
| reg_we | output | 1 | Register file write strobe |
| reg_re | output | 1 | Register file read strobe |
| reg_rdata | input | 128 | Register file read data, combinational |

## Verification
Reads are tried in three orders:
- walking upward through one register, which separates a latch hit from a fresh sample;
- jumping to another register's upper dword, which shows that only the latched base counts as a hit;
- putting a single-dword read between wide reads, which shows the latch is left alone.

Writes are tried in order, out of order and interleaved with other registers. This separates a collector that commits on a full mask from one that commits on the last address. Descriptor writes are mixed with half-collected normal registers to tell a drop from a merge, and a restart from a retention. A timer write and an event-pointer write are each inserted in the middle of a collection to tell a clear from a bypass.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  localparam int DWORD_W = 32;
  localparam int NDW     = 4;
  localparam int WIDE_W  = DWORD_W * NDW;

  typedef enum logic [1:0] {
    K_WIDE   = 2'd0,
    K_DESC   = 2'd1,
    K_NARROW = 2'd2,
    K_TIMER  = 2'd3
  } wreg_kind_e;

  typedef logic [NDW-1:0][DWORD_W-1:0] wide_t;
endpackage

// File: rtl/wreg_decode.sv
module wreg_decode
  import wreg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_BITS = 13,
  parameter logic [12:0] DESC_A    = 13'h830,
  parameter logic [12:0] DESC_B    = 13'hA10,
  parameter logic [12:0] EVQ_OFS   = 13'h400,
  parameter logic [12:0] TIMER_OFS = 13'h420
) (
  input  logic [ADDR_W-1:0] addr,
  output wreg_kind_e        kind,
  output logic [ADDR_W-1:0] base,
  output logic [1:0]        dw
);
  logic [PAGE_BITS-1:0] ofs;

  always_comb begin
    ofs  = addr[PAGE_BITS-1:0];
    base = {addr[ADDR_W-1:4], 4'b0};
    dw   = addr[3:2];
    if (ofs[PAGE_BITS-1:2] == TIMER_OFS[PAGE_BITS-1:2])      kind = K_TIMER;
    else if (ofs[PAGE_BITS-1:2] == EVQ_OFS[PAGE_BITS-1:2])   kind = K_NARROW;
    else if (ofs[PAGE_BITS-1:4] == DESC_A[PAGE_BITS-1:4] ||
             ofs[PAGE_BITS-1:4] == DESC_B[PAGE_BITS-1:4])    kind = K_DESC;
    else                                                     kind = K_WIDE;
  end
endmodule

// File: rtl/wreg_read_latch.sv
module wreg_read_latch
  import wreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_rd,
  input  logic                narrow_rd,
  input  logic [ADDR_W-1:0]   base,
  input  logic [1:0]          dw,
  input  logic [WIDE_W-1:0]   rdata_wide,
  output logic                rd_req,
  output logic                hit,
  output logic [DWORD_W-1:0]  rdata,
  output wide_t               lat_data
);
  logic              lat_vld, nxt_vld, sample;
  logic [ADDR_W-1:0] lat_addr, nxt_addr;
  wide_t             src, nxt_data;

  always_comb begin
    src      = wide_t'(rdata_wide);
    hit      = wide_rd && lat_vld && (lat_addr == base) && (dw != 2'd0);
    sample   = wide_rd && !hit;
    rd_req   = sample || narrow_rd;
    nxt_vld  = lat_vld;
    nxt_addr = lat_addr;
    nxt_data = lat_data;
    if (sample) begin
      nxt_vld  = 1'b1;
      nxt_addr = base;
      nxt_data = src;
    end
    if (hit)            rdata = lat_data[dw];
    else if (narrow_rd) rdata = src[0];
    else                rdata = src[dw];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_vld  <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else if (sample) begin
      lat_vld  <= nxt_vld;
      lat_addr <= nxt_addr;
      lat_data <= nxt_data;
    end
  end
endmodule

// File: rtl/wreg_collector.sv
module wreg_collector
  import wreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               is_desc,
  input  logic               clr,
  input  logic [ADDR_W-1:0]  base,
  input  logic [1:0]         dw,
  input  logic [DWORD_W-1:0] wdata,
  output logic               commit,
  output wide_t              commit_data,
  output logic               drop,
  output logic [NDW-1:0]     col_mask
);
  logic [ADDR_W-1:0] col_addr, nxt_addr;
  logic [NDW-1:0]    nxt_mask, mmask, bitd;
  wide_t             col_data, nxt_data, mdata;
  logic              other, upd;

  always_comb begin
    other       = (col_mask != '0) && (col_addr != base);
    bitd        = NDW'(1) << dw;
    mdata       = other ? '0 : col_data;
    mdata[dw]   = wdata;
    mmask       = (other ? '0 : col_mask) | bitd;
    nxt_mask    = col_mask;
    nxt_addr    = col_addr;
    nxt_data    = col_data;
    commit      = 1'b0;
    drop        = 1'b0;
    commit_data = '0;
    if (clr) begin
      nxt_mask = '0;
    end else if (wr_en) begin
      if (is_desc && dw == 2'(NDW-1)) begin
        commit = 1'b1;
        for (int i = 0; i < NDW; i++)
          commit_data[i] = mmask[i] ? mdata[i] : '0;
        nxt_mask = other ? col_mask : '0;
      end else if (is_desc && other) begin
        drop = 1'b1;
      end else if (mmask == '1) begin
        commit      = 1'b1;
        commit_data = mdata;
        nxt_mask    = '0;
      end else begin
        nxt_mask = mmask;
        nxt_addr = base;
        nxt_data = mdata;
      end
    end
    upd = clr || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_mask <= '0;
      col_addr <= '0;
      col_data <= '0;
    end else if (upd) begin
      col_mask <= nxt_mask;
      col_addr <= nxt_addr;
      col_data <= nxt_data;
    end
  end
endmodule

// File: rtl/wreg_bridge.sv
module wreg_bridge
  import wreg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_BITS = 13,
  parameter logic [12:0] DESC_A    = 13'h830,
  parameter logic [12:0] DESC_B    = 13'hA10,
  parameter logic [12:0] EVQ_OFS   = 13'h400,
  parameter logic [12:0] TIMER_OFS = 13'h420
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_valid,
  input  logic                host_write,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DWORD_W-1:0]  host_wdata,
  output logic [DWORD_W-1:0]  host_rdata,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [WIDE_W-1:0]   reg_wdata,
  output logic                reg_we,
  output logic                reg_re,
  input  logic [WIDE_W-1:0]   reg_rdata
);
  logic              rst_s1, rst_s;
  wreg_kind_e        kind;
  logic [ADDR_W-1:0] base;
  logic [1:0]        dw;
  logic              wr, rd, single, wide_rd, narrow_rd;
  logic              rd_req, lat_hit, commit, drop;
  wide_t             lat_data, commit_data;
  logic [NDW-1:0]    col_mask;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  wreg_decode #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DESC_A(DESC_A),
    .DESC_B(DESC_B), .EVQ_OFS(EVQ_OFS), .TIMER_OFS(TIMER_OFS)
  ) u_dec (
    .addr(host_addr), .kind(kind), .base(base), .dw(dw)
  );

  always_comb begin
    wr        = host_valid && host_write;
    rd        = host_valid && !host_write;
    single    = (kind == K_NARROW) || (kind == K_TIMER);
    wide_rd   = rd && !single;
    narrow_rd = rd && single;
  end

  wreg_read_latch #(.ADDR_W(ADDR_W)) u_rl (
    .clk(clk), .rst_n(rst_s), .wide_rd(wide_rd), .narrow_rd(narrow_rd),
    .base(base), .dw(dw), .rdata_wide(reg_rdata), .rd_req(rd_req),
    .hit(lat_hit), .rdata(host_rdata), .lat_data(lat_data)
  );

  wreg_collector #(.ADDR_W(ADDR_W)) u_col (
    .clk(clk), .rst_n(rst_s), .wr_en(wr && !single),
    .is_desc(kind == K_DESC), .clr(wr && kind == K_TIMER),
    .base(base), .dw(dw), .wdata(host_wdata), .commit(commit),
    .commit_data(commit_data), .drop(drop), .col_mask(col_mask)
  );

  always_comb begin
    reg_re    = rd_req;
    reg_we    = commit || (wr && single);
    reg_wdata = commit ? WIDE_W'(commit_data) : {{(WIDE_W-DWORD_W){1'b0}}, host_wdata};
    reg_addr  = single ? {host_addr[ADDR_W-1:2], 2'b0} : base;
  end
endmodule

// File: rtl/wreg_bridge_chk.sv
module wreg_bridge_chk
  import wreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_s,
  input logic              host_valid,
  input logic              host_write,
  input wreg_kind_e        kind,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              lat_hit,
  input wide_t             lat_data,
  input logic              drop,
  input logic [NDW-1:0]    col_mask
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s)
    !host_valid |-> (!reg_we && !reg_re));
  p_read_no_write_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (host_valid && !host_write) |-> !reg_we);
  p_write_no_read_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (host_valid && host_write) |-> !reg_re);
  p_hit_no_sample_r3: assert property (@(posedge clk) disable iff (!rst_s)
    lat_hit |-> !reg_re);
  p_hit_holds_latch_r3: assert property (@(posedge clk) disable iff (!rst_s)
    lat_hit |=> $stable(lat_data));
  p_timer_clears_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (host_valid && host_write && kind == K_TIMER) |=> (col_mask == '0));
  p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_s)
    drop |=> $stable(col_mask));
  p_wide_aligned_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_we && (kind == K_WIDE || kind == K_DESC)) |-> (reg_addr[3:0] == 4'h0));
endmodule

bind wreg_bridge wreg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .host_valid(host_valid), .host_write(host_write),
  .kind(kind), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
  .lat_hit(lat_hit), .lat_data(lat_data), .drop(drop), .col_mask(col_mask)
);

// File: tb/wreg_bridge_tb.sv
module wreg_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NV = 46;

  typedef struct packed {
    logic          wr;
    logic [15:0]   addr;
    logic [31:0]   wd;
    logic          ewe;
    logic          ere;
    logic [15:0]   eaddr;
    logic [127:0]  ewd;
    logic [31:0]   erd;
    logic [3:0]    req;
  } vec_t;

  function automatic vec_t rv(logic [15:0] a, logic ere, logic [15:0] ea,
                              logic [31:0] erd, logic [3:0] rq);
    return '{wr:1'b0, addr:a, wd:32'h0, ewe:1'b0, ere:ere, eaddr:ea,
             ewd:128'h0, erd:erd, req:rq};
  endfunction

  function automatic vec_t wv(logic [15:0] a, logic [31:0] d, logic ewe,
                              logic [15:0] ea, logic [127:0] ewd, logic [3:0] rq);
    return '{wr:1'b1, addr:a, wd:d, ewe:ewe, ere:1'b0, eaddr:ea,
             ewd:ewd, erd:32'h0, req:rq};
  endfunction

  // read model data: {8'hD0+dword, read count, register address}
  localparam vec_t TBL [NV] = '{
    rv(16'h0010, 1, 16'h0010, 32'hD000_0010, 2),  // R2 first dword samples
    rv(16'h0018, 0, 16'h0000, 32'hD200_0010, 3),  // R3 hit
    rv(16'h001C, 0, 16'h0000, 32'hD300_0010, 3),  // R3 hit
    rv(16'h0024, 1, 16'h0020, 32'hD101_0020, 2),  // R2 other register
    rv(16'h0014, 1, 16'h0010, 32'hD102_0010, 2),  // R2 no longer latched
    rv(16'h0010, 1, 16'h0010, 32'hD003_0010, 2),  // R2 dword 0 re-samples
    rv(16'h0400, 1, 16'h0400, 32'hD004_0400, 4),  // R4 single dword
    rv(16'h0018, 0, 16'h0000, 32'hD203_0010, 4),  // R4 latch kept
    wv(16'h0100, 32'h1111_1111, 0, 16'h0, 128'h0, 5),  // R5
    wv(16'h0108, 32'h2222_2222, 0, 16'h0, 128'h0, 5),
    wv(16'h0104, 32'h3333_3333, 0, 16'h0, 128'h0, 5),
    wv(16'h010C, 32'h4444_4444, 1, 16'h0100,
       {32'h4444_4444, 32'h2222_2222, 32'h3333_3333, 32'h1111_1111}, 5),
    wv(16'h020C, 32'hAAAA_0003, 0, 16'h0, 128'h0, 6),  // R6
    wv(16'h0304, 32'hBBBB_0001, 0, 16'h0, 128'h0, 6),
    wv(16'h0300, 32'hBBBB_0000, 0, 16'h0, 128'h0, 6),
    wv(16'h0308, 32'hBBBB_0002, 0, 16'h0, 128'h0, 6),
    wv(16'h030C, 32'hBBBB_0003, 1, 16'h0300,
       {32'hBBBB_0003, 32'hBBBB_0002, 32'hBBBB_0001, 32'hBBBB_0000}, 6),
    wv(16'h0500, 32'h5555_0000, 0, 16'h0, 128'h0, 9),  // R9
    wv(16'h0504, 32'h5555_0001, 0, 16'h0, 128'h0, 9),
    wv(16'h0420, 32'h0000_0007, 1, 16'h0420, {96'h0, 32'h0000_0007}, 9),
    wv(16'h0508, 32'h5555_0002, 0, 16'h0, 128'h0, 9),
    wv(16'h050C, 32'h5555_0003, 0, 16'h0, 128'h0, 9),
    wv(16'h0500, 32'h6666_0000, 0, 16'h0, 128'h0, 9),
    wv(16'h0504, 32'h6666_0001, 1, 16'h0500,
       {32'h5555_0003, 32'h5555_0002, 32'h6666_0001, 32'h6666_0000}, 9),
    wv(16'h0600, 32'h6161_0000, 0, 16'h0, 128'h0, 10),  // R10
    wv(16'h0604, 32'h6161_0001, 0, 16'h0, 128'h0, 10),
    wv(16'h0608, 32'h6161_0002, 0, 16'h0, 128'h0, 10),
    wv(16'h0400, 32'h0000_ABCD, 1, 16'h0400, {96'h0, 32'h0000_ABCD}, 10),
    wv(16'h060C, 32'h6161_0003, 1, 16'h0600,
       {32'h6161_0003, 32'h6161_0002, 32'h6161_0001, 32'h6161_0000}, 10),
    wv(16'h0838, 32'h8888_0002, 0, 16'h0, 128'h0, 7),  // R7
    wv(16'h083C, 32'h8888_0003, 1, 16'h0830,
       {32'h8888_0003, 32'h8888_0002, 64'h0}, 7),
    wv(16'h0700, 32'h7777_0000, 0, 16'h0, 128'h0, 8),  // R8
    wv(16'h0A14, 32'hDEAD_0001, 0, 16'h0, 128'h0, 8),  // R8 dropped
    wv(16'h0704, 32'h7777_0001, 0, 16'h0, 128'h0, 8),
    wv(16'h0708, 32'h7777_0002, 0, 16'h0, 128'h0, 8),
    wv(16'h070C, 32'h7777_0003, 1, 16'h0700,
       {32'h7777_0003, 32'h7777_0002, 32'h7777_0001, 32'h7777_0000}, 8),
    wv(16'h0A1C, 32'hA1A1_0003, 1, 16'h0A10, {32'hA1A1_0003, 96'h0}, 8),
    wv(16'h0900, 32'h9999_0000, 0, 16'h0, 128'h0, 12),  // R12
    wv(16'h0A1C, 32'hA2A2_0003, 1, 16'h0A10, {32'hA2A2_0003, 96'h0}, 12),
    wv(16'h0904, 32'h9999_0001, 0, 16'h0, 128'h0, 12),
    wv(16'h0908, 32'h9999_0002, 0, 16'h0, 128'h0, 12),
    wv(16'h090C, 32'h9999_0003, 1, 16'h0900,
       {32'h9999_0003, 32'h9999_0002, 32'h9999_0001, 32'h9999_0000}, 12),
    wv(16'h2838, 32'h2828_0002, 0, 16'h0, 128'h0, 1),  // R1 page 1
    wv(16'h283C, 32'h2828_0003, 1, 16'h2830,
       {32'h2828_0003, 32'h2828_0002, 64'h0}, 1),
    rv(16'h4400, 1, 16'h4400, 32'hD005_4400, 1),  // R1 page 2 single dword
    rv(16'h0018, 0, 16'h0000, 32'hD203_0010, 1)   // R1 latch kept
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_valid = 1'b0;
  logic          host_write = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic [AW-1:0] reg_addr;
  logic [127:0]  reg_wdata;
  logic          reg_we, reg_re;
  logic [127:0]  reg_rdata;
  logic [7:0]    rd_cnt = 8'd0;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model: every sample has a distinct count
  assign reg_rdata = {8'hD3, rd_cnt, reg_addr, 8'hD2, rd_cnt, reg_addr,
                      8'hD1, rd_cnt, reg_addr, 8'hD0, rd_cnt, reg_addr};
  always @(posedge clk) if (reg_re) rd_cnt <= rd_cnt + 8'd1;

  wreg_bridge #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  task automatic chk(bit ok, int rq, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic beat(logic w, logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1;
    host_write = w;
    host_addr  = a;
    host_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    host_valid = 1'b0;
    host_write = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R11 quiet after reset
    chk(!reg_we && !reg_re, 11, "strobes idle after reset",
        {reg_we, reg_re}, 128'h0);

    for (int i = 0; i < NV; i++) begin
      beat(TBL[i].wr, TBL[i].addr, TBL[i].wd);
      chk(reg_we == TBL[i].ewe, TBL[i].req, $sformatf("reg_we vec %0d", i),
          reg_we, TBL[i].ewe);
      chk(reg_re == TBL[i].ere, TBL[i].req, $sformatf("reg_re vec %0d", i),
          reg_re, TBL[i].ere);
      if (TBL[i].ewe) begin
        chk(reg_addr == TBL[i].eaddr, TBL[i].req, $sformatf("write addr vec %0d", i),
            reg_addr, TBL[i].eaddr);
        chk(reg_wdata == TBL[i].ewd, TBL[i].req, $sformatf("write data vec %0d", i),
            reg_wdata, TBL[i].ewd);
      end
      if (!TBL[i].wr) begin
        if (TBL[i].ere)
          chk(reg_addr == TBL[i].eaddr, TBL[i].req, $sformatf("read addr vec %0d", i),
              reg_addr, TBL[i].eaddr);
        chk(host_rdata == TBL[i].erd, TBL[i].req, $sformatf("read data vec %0d", i),
            host_rdata, TBL[i].erd);
      end
    end

    // R11: reset in the middle of a collection drops it and empties the latch
    beat(1'b1, 16'h0B00, 32'hB0B0_0000);
    beat(1'b1, 16'h0B04, 32'hB0B0_0001);
    beat(1'b1, 16'h0B08, 32'hB0B0_0002);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!reg_we && !reg_re, 11, "strobes idle after second reset",
        {reg_we, reg_re}, 128'h0);
    beat(1'b1, 16'h0B0C, 32'hB0B0_0003);
    chk(reg_we == 1'b0, 11, "collector empty after reset", reg_we, 1'b0);
    beat(1'b0, 16'h0018, 32'h0);
    chk(reg_re == 1'b1, 11, "latch empty after reset", reg_re, 1'b1);
    idle();
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule